// File: doc/BRIEF.md
# Multi-core start request allocator

This block hands out processor cores from a pool of sixteen to start requests. It holds a bitmap of the cores that are running and a candidate mask written by software. Three kinds of request are served. A single request takes one free core that the mask permits. A pair request takes two free cores whose ids are consecutive. A multi request names a set of wanted cores as a bitmap. The block tries that bitmap at every rotation, one rotation per clock, until no wanted core lands on a running one. The block does not run the cores or load their code. It only drives a start strobe per core, with the code address, and a stop strobe per core.

A requester raises a request for one cycle and then waits. Busy is high while the search runs. The search ends with a one-cycle done pulse or a one-cycle fail pulse. On done, the granted id or the rotation amount appears on the grant output in the same cycle as the start strobes. Stop commands can arrive at any time. Those that arrive during a search are held back until the search has finished, so a search always sees a fixed running bitmap.

Top module: `core_launch_alloc`

## Requirements
- R1: After reset, busy, done and fail are 0, the running bitmap is 0, no start or stop strobe is active, and the candidate mask holds all ones.
- R2: A request is sampled on a clock edge while busy is low. A single request (kind code 0) grants the lowest core id that is free and has its mask bit set. Done is pulsed in the second cycle after the request cycle. In that same cycle the start strobe is one-hot at the granted id, grantId carries the id, startAddr carries the request address, and the running bitmap gains that bit.
- R3: Writing the mask (maskWe, maskData) takes effect on the next cycle. Bit i set means core i may be granted to a single request. Cores with a clear mask bit are skipped. If no core is eligible, fail is pulsed in the second cycle after the request, and no core starts.
- R4: A pair request (kind code 1) grants the lowest n for which cores n and n+1 are both free, ignoring the mask. Both start strobes fire in the same cycle with the same address. grantId is n, and done follows the single-request timing.
- R5: Pair adjacency does not wrap, so cores 15 and 0 are not a pair. A failed request leaves the running bitmap unchanged.
- R6: A multi request (kind code 2) tries rotations r = 0, 1, 2 … of the request bitmap, rotated left (bit i moves to bit (i+r) mod 16), one per cycle. It takes the first r at which the rotated bitmap shares no bit with the running bitmap. Done comes 2+r cycles after the request cycle. At that point the rotated bitmap is the start strobe and is ORed into the running bitmap, and grantId is r.
- R7: A multi request that fits at none of the 16 rotations pulses fail 17 cycles after the request. Busy is high from the cycle after the request until done or fail. Done and fail each last one cycle, and they never occur together.
- R8: A stop (stopValid with stopId) while busy is low clears that core's running bit in the next cycle, with a one-hot stop strobe in that cycle.
- R9: A stop that arrives while busy is high leaves the running bitmap untouched during the search. It is applied, with its stop strobe, in the cycle after done or fail.
- R10: A request raised while busy is high is ignored. No second search starts and no extra done or fail follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request strobe, sampled while not busy |
| reqKind | input | 2 | 0 single, 1 pair, 2 multi |
| reqAddr | input | 20 | Code address passed to the started cores |
| reqMap | input | 16 | Wanted-core bitmap for multi requests |
| maskWe | input | 1 | Candidate mask write enable |
| maskData | input | 16 | New candidate mask |
| stopValid | input | 1 | Stop strobe |
| stopId | input | 4 | Core to stop |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| grantId | output | 4 | Granted id, lower id of a pair, or rotation amount |
| startStrobe | output | 16 | Per-core start pulse |
| startAddr | output | 20 | Code address for the started cores |
| stopStrobe | output | 16 | Per-core stop pulse |
| runMap | output | 16 | Running-core bitmap |

## Verification
The hardest case is a multi request that has to go through every rotation. To reach it, the bench first fills the running bitmap to a chosen pattern using multi requests and stops. Cores 0 and 15 are left free, and a two-core request then fits only at the last rotation. The same filled pool gives a pair request whose only free neighbours wrap around, and a full-length failing search. During that failing search the bench raises both a stop and a stray request, to show that the stop is deferred and the request is ignored.

// File: rtl/core_alloc_pkg.sv
package core_alloc_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_PAIR   = 2'd1,
    KIND_MULTI  = 2'd2,
    KIND_RSVD   = 2'd3
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic stepRot;
    logic commit;
    logic abort;
    logic applyStops;
  } allocStrb_t;

  // search status from datapath to control
  typedef struct packed {
    logic hit;
    logic rotLast;
    logic isMulti;
  } allocStat_t;

endpackage

// File: rtl/core_alloc_ctrl.sv
module core_alloc_ctrl
  import core_alloc_pkg::*;
#(
  parameter int NUM_CORES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  allocStat_t stat,
  output allocStrb_t strb,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  localparam int CNT_W = $clog2(NUM_CORES + 2);

  typedef enum logic {ST_IDLE, ST_SEARCH} state_e;
  state_e state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        strb.applyStops = 1'b1;
        if (reqValid) begin
          strb.accept = 1'b1;
          stateNext   = ST_SEARCH;
        end
      end
      default: begin
        if (stat.hit) begin
          strb.commit = 1'b1;
          stateNext   = ST_IDLE;
        end else if (!stat.isMulti || stat.rotLast) begin
          strb.abort = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          strb.stepRot = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.commit;
      fail  <= strb.abort;
    end
  end

  assign busy = (state == ST_SEARCH);

  // bounded search length, counted outside the FSM
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busyCnt <= '0;
    else if (busy)  busyCnt <= busyCnt + 1'b1;
    else            busyCnt <= '0;
  end

  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(NUM_CORES)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |=> !(done || fail)); // R7
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail)); // R7
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail) |-> !busy); // R10

endmodule

// File: rtl/core_alloc_dp.sv
module core_alloc_dp
  import core_alloc_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int ADDR_W    = 20,
  parameter int ID_W      = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  allocStrb_t           strb,
  output allocStat_t           stat,
  input  logic [1:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_CORES-1:0] reqMap,
  input  logic                 maskWe,
  input  logic [NUM_CORES-1:0] maskData,
  input  logic                 stopValid,
  input  logic [ID_W-1:0]      stopId,
  output logic [ID_W-1:0]      grantId,
  output logic [NUM_CORES-1:0] startStrobe,
  output logic [ADDR_W-1:0]    startAddr,
  output logic [NUM_CORES-1:0] stopStrobe,
  output logic [NUM_CORES-1:0] runMap
);

  reqKind_e             kindQ;
  logic [ADDR_W-1:0]    addrQ;
  logic [NUM_CORES-1:0] mapQ;
  logic [ID_W-1:0]      rotQ;
  logic [NUM_CORES-1:0] candMask;
  logic [NUM_CORES-1:0] pendStop;

  function automatic logic [NUM_CORES-1:0] rotL(input logic [NUM_CORES-1:0] v,
                                                input logic [ID_W-1:0] r);
    logic [2*NUM_CORES-1:0] d;
    d = {v, v} << r;
    return d[2*NUM_CORES-1 -: NUM_CORES];
  endfunction

  logic [NUM_CORES-1:0] freeMap, singleElig, rotated, stopNow, grantNext;
  logic [NUM_CORES-2:0] pairElig;
  logic [ID_W-1:0]      singleId, pairId, grantIdNext;
  logic                 singleHit, pairHit, multiHit;

  assign freeMap    = ~runMap;
  assign singleElig = freeMap & candMask;
  assign rotated    = rotL(mapQ, rotQ);
  assign multiHit   = (rotated & runMap) == '0;
  assign stopNow    = stopValid ? (NUM_CORES'(1) << stopId) : '0;

  for (genvar g = 0; g < NUM_CORES - 1; g++) begin : g_pair
    assign pairElig[g] = freeMap[g] & freeMap[g+1];
  end

  always_comb begin
    singleId  = '0;
    singleHit = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (singleElig[i]) begin
        singleId  = ID_W'(i);
        singleHit = 1'b1;
      end
    end
  end

  always_comb begin
    pairId  = '0;
    pairHit = 1'b0;
    for (int i = NUM_CORES - 2; i >= 0; i--) begin
      if (pairElig[i]) begin
        pairId  = ID_W'(i);
        pairHit = 1'b1;
      end
    end
  end

  always_comb begin
    stat.isMulti = (kindQ == KIND_MULTI);
    stat.rotLast = (rotQ == ID_W'(NUM_CORES - 1));
    case (kindQ)
      KIND_SINGLE: begin
        stat.hit    = singleHit;
        grantNext   = NUM_CORES'(1) << singleId;
        grantIdNext = singleId;
      end
      KIND_PAIR: begin
        stat.hit    = pairHit;
        grantNext   = NUM_CORES'(3) << pairId;
        grantIdNext = pairId;
      end
      KIND_MULTI: begin
        stat.hit    = multiHit;
        grantNext   = rotated;
        grantIdNext = rotQ;
      end
      default: begin
        stat.hit    = 1'b0;
        grantNext   = '0;
        grantIdNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ       <= KIND_SINGLE;
      addrQ       <= '0;
      mapQ        <= '0;
      rotQ        <= '0;
      candMask    <= '1;
      pendStop    <= '0;
      runMap      <= '0;
      grantId     <= '0;
      startStrobe <= '0;
      startAddr   <= '0;
      stopStrobe  <= '0;
    end else begin
      startStrobe <= '0;
      stopStrobe  <= '0;
      if (maskWe) candMask <= maskData;
      if (strb.accept) begin
        kindQ <= reqKind_e'(reqKind);
        addrQ <= reqAddr;
        mapQ  <= reqMap;
        rotQ  <= '0;
      end
      if (strb.stepRot) rotQ <= rotQ + 1'b1;
      if (strb.commit) begin
        runMap      <= runMap | grantNext;
        startStrobe <= grantNext;
        startAddr   <= addrQ;
        grantId     <= grantIdNext;
      end
      if (strb.applyStops) begin
        runMap     <= runMap & ~(pendStop | stopNow);
        stopStrobe <= pendStop | stopNow;
        pendStop   <= '0;
      end else begin
        pendStop <= pendStop | stopNow;
      end
    end
  end

  AST_START_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe != '0) |-> (($past(runMap) & startStrobe) == '0)); // R2
  AST_SINGLE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && kindQ == KIND_SINGLE) |->
      ($countones(startStrobe) == 1 && (startStrobe & $past(candMask)) != '0)); // R3
  AST_PAIR_ADJ: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.commit && kindQ == KIND_PAIR) |->
      ($countones(startStrobe) == 2 && (startStrobe & (startStrobe >> 1)) != '0)); // R4
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> ($stable(runMap) && startStrobe == '0)); // R5
  AST_STOP_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepRot |=> $stable(runMap)); // R9

endmodule

// File: rtl/core_launch_alloc.sv
module core_launch_alloc
  import core_alloc_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int ADDR_W    = 20,
  parameter int ID_W      = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_CORES-1:0] reqMap,
  input  logic                 maskWe,
  input  logic [NUM_CORES-1:0] maskData,
  input  logic                 stopValid,
  input  logic [ID_W-1:0]      stopId,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic [ID_W-1:0]      grantId,
  output logic [NUM_CORES-1:0] startStrobe,
  output logic [ADDR_W-1:0]    startAddr,
  output logic [NUM_CORES-1:0] stopStrobe,
  output logic [NUM_CORES-1:0] runMap
);

  allocStrb_t strb;
  allocStat_t stat;

  core_alloc_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stat(stat), .strb(strb),
    .busy(busy), .done(done), .fail(fail)
  );

  core_alloc_dp #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stat(stat),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqMap(reqMap),
    .maskWe(maskWe), .maskData(maskData),
    .stopValid(stopValid), .stopId(stopId),
    .grantId(grantId), .startStrobe(startStrobe), .startAddr(startAddr),
    .stopStrobe(stopStrobe), .runMap(runMap)
  );

endmodule

// File: tb/core_launch_alloc_bench.sv
`timescale 1ns/1ps
module core_launch_alloc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqMap = '0;
  logic        maskWe = 1'b0;
  logic [15:0] maskData = '0;
  logic        stopValid = 1'b0;
  logic [3:0]  stopId = '0;
  logic        busy, done, fail;
  logic [3:0]  grantId;
  logic [15:0] startStrobe, stopStrobe, runMap;
  logic [19:0] startAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  core_launch_alloc u_core_launch_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqMap(reqMap), .maskWe(maskWe), .maskData(maskData),
    .stopValid(stopValid), .stopId(stopId), .busy(busy), .done(done),
    .fail(fail), .grantId(grantId), .startStrobe(startStrobe),
    .startAddr(startAddr), .stopStrobe(stopStrobe), .runMap(runMap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic doReq(input logic [1:0] k, input logic [15:0] m, input logic [19:0] a,
                       output int lat, output logic ok);
    reqKind = k; reqMap = m; reqAddr = a; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!done && !fail && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    ok = done;
  endtask

  task automatic doStop(input logic [3:0] id);
    stopValid = 1'b1; stopId = id;
    @(negedge clk);
    stopValid = 1'b0;
  endtask

  task automatic writeMask(input logic [15:0] m);
    maskWe = 1'b1; maskData = m;
    @(negedge clk);
    maskWe = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 busy", busy, 0);
    chk("R1 done/fail", {done, fail}, 0);
    chk("R1 runMap", runMap, 0);
    chk("R1 strobes", {startStrobe, stopStrobe}, 0);
  endtask

  task automatic testSingle();
    int lat; logic ok;
    doReq(2'd0, 16'h0, 20'h12345, lat, ok);
    chk("R2 done", ok, 1);
    chk("R2 latency", lat, 2);
    chk("R2 R1 grant lowest with reset mask", grantId, 0);
    chk("R2 startStrobe", startStrobe, 16'h0001);
    chk("R2 startAddr", startAddr, 20'h12345);
    chk("R2 runMap", runMap, 16'h0001);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
    chk("R2 strobe one cycle", startStrobe, 0);
    doReq(2'd0, 16'h0, 20'h00777, lat, ok);
    chk("R2 second grant", grantId, 1);
    chk("R2 runMap two", runMap, 16'h0003);
  endtask

  task automatic testMask();
    int lat; logic ok;
    writeMask(16'hFFE0);
    doReq(2'd0, 16'h0, 20'h00055, lat, ok);
    chk("R3 masked skip grant", grantId, 5);
    chk("R3 masked skip strobe", startStrobe, 16'h0020);
    writeMask(16'h0003);
    doReq(2'd0, 16'h0, 20'h00066, lat, ok);
    chk("R3 no eligible fails", {ok, fail}, 2'b01);
    chk("R3 fail latency", lat, 2);
    chk("R3 no start", startStrobe, 0);
    chk("R3 runMap kept", runMap, 16'h0023);
    writeMask(16'hFFFF);
  endtask

  task automatic testPair();
    int lat; logic ok;
    doReq(2'd1, 16'h0, 20'h0ABCD, lat, ok);
    chk("R4 pair done", ok, 1);
    chk("R4 pair latency", lat, 2);
    chk("R4 pair lower id", grantId, 2);
    chk("R4 pair strobes", startStrobe, 16'h000C);
    chk("R4 pair addr", startAddr, 20'h0ABCD);
    chk("R4 runMap", runMap, 16'h002F);
  endtask

  task automatic testStopIdle();
    doStop(4'd5);
    chk("R8 runMap cleared", runMap, 16'h000F);
    chk("R8 stopStrobe", stopStrobe, 16'h0020);
  endtask

  task automatic testNoWrap();
    int lat; logic ok;
    doReq(2'd2, 16'h7FF0, 20'h00100, lat, ok);
    chk("R6 fit at rotation 0", {ok, grantId}, {1'b1, 4'd0});
    chk("R6 latency rot0", lat, 2);
    chk("R6 runMap OR", runMap, 16'h7FFF);
    doStop(4'd0);
    chk("R8 stop core0", runMap, 16'h7FFE);
    doReq(2'd1, 16'h0, 20'h00200, lat, ok);
    chk("R5 wrap pair fails", {ok, fail}, 2'b01);
    chk("R5 runMap unchanged", runMap, 16'h7FFE);
  endtask

  task automatic testMultiLast();
    int lat; logic ok;
    doReq(2'd2, 16'h0003, 20'h00300, lat, ok);
    chk("R6 fits last rotation", ok, 1);
    chk("R6 rotation amount", grantId, 15);
    chk("R6 latency rot15", lat, 17);
    chk("R6 rotated strobes", startStrobe, 16'h8001);
    chk("R6 runMap full", runMap, 16'hFFFF);
  endtask

  task automatic testMultiFailDeferred();
    int lat;
    reqKind = 2'd2; reqMap = 16'h0001; reqAddr = 20'h00400; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    chk("R7 busy during search", busy, 1);
    @(negedge clk); lat++;
    stopValid = 1'b1; stopId = 4'd3;
    @(negedge clk); lat++;
    stopValid = 1'b0;
    reqKind = 2'd0; reqValid = 1'b1;
    @(negedge clk); lat++;
    reqValid = 1'b0;
    chk("R9 runMap held during search", runMap, 16'hFFFF);
    while (!done && !fail && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R7 multi fails", {done, fail}, 2'b01);
    chk("R7 fail latency", lat, 17);
    chk("R9 runMap at fail", runMap, 16'hFFFF);
    @(negedge clk);
    chk("R9 deferred stop applied", runMap, 16'hFFF7);
    chk("R9 deferred stop strobe", stopStrobe, 16'h0008);
    chk("R10 not busy", busy, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 ignored request", {busy, done, fail, startStrobe}, 0);
    end
  endtask

  task automatic testMultiMid();
    int lat; logic ok;
    doReq(2'd2, 16'h0001, 20'h00500, lat, ok);
    chk("R6 mid rotation done", ok, 1);
    chk("R6 mid rotation amount", grantId, 3);
    chk("R6 mid latency", lat, 5);
    chk("R6 mid strobe", startStrobe, 16'h0008);
    chk("R6 mid runMap", runMap, 16'hFFFF);
  endtask

  task automatic testFullSingle();
    int lat; logic ok;
    doReq(2'd0, 16'h0, 20'h00600, lat, ok);
    chk("R3 full pool single fails", {ok, fail}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testMask();
    testPair();
    testStopIdle();
    testNoWrap();
    testMultiLast();
    testMultiFailDeferred();
    testMultiMid();
    testFullSingle();
    repeat (2) @(negedge clk);
    finishUp();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishUp();
  end

endmodule